// File: doc/BRIEF.md
# Slave Serial Configuration Loader

This block loads a configuration bitstream into a programmable target device over a bit-serial link. The bitstream arrives as bytes on a valid/ready stream. The block drives three pins on the target: an active-low program pin, a serial data pin and a configuration clock pin. It watches two pins that come back from the target: an active-low init pin and a done pin. One pulse on `start_i` runs a complete load. The block pulses program low, waits for init to go high, shifts every bit out with one clock pulse per bit, then sends trailing ones until done rises. It ends with a sticky success or error flag.

The controller is a single enumerated state machine, and every state is listed here with its exits:
- `ST_IDLE`, `ST_PASS` and `ST_FAIL` go to `ST_PROG_LOW` on `start_i`.
- `ST_PROG_LOW` holds program low and goes to `ST_INIT_WAIT` when the phase timer expires.
- `ST_INIT_WAIT` goes to `ST_FETCH` when init reads high, or to `ST_FAIL` when the watchdog expires.
- `ST_FETCH` raises ready and goes to `ST_SHIFT_LO` when a byte is taken.
- `ST_SHIFT_LO` presents a bit with the clock low for one half period, then goes to `ST_SHIFT_HI`.
- `ST_SHIFT_HI` holds the clock high for one half period. It then goes back to `ST_SHIFT_LO` for the next bit, to `ST_FETCH` after the eighth bit of an ordinary byte, or to `ST_TRAIL_LO` after the eighth bit of the last byte. Init low in either shift state goes to `ST_FAIL`.
- `ST_TRAIL_LO` and `ST_TRAIL_HI` alternate, clocking ones. Done high goes to `ST_PASS`. Expiry of the done watchdog goes to `ST_FAIL`.

Top module: `cfg_serial_loader`

## Requirements
- R1: After `start_i`, `dev_prog_n_o` is driven low for exactly PROG_LOW_CYCLES clock cycles and then stays high for the rest of the load. `dev_cclk_o` is never high while `dev_prog_n_o` is low.
- R2: After program is released, no byte is accepted and no clock pulse is given until `dev_init_n_i` reads high. If init stays low for INIT_TIMEOUT_CYCLES cycles, the load ends in error with no clock pulse at all.
- R3: Each bit is placed on `dev_din_o` while `dev_cclk_o` is low, and stays stable while the clock is high. Each phase lasts HALF_PERIOD_CYCLES cycles. Bits go out most significant bit first, so the bit sampled at the n-th rising clock edge is bit 7-(n mod 8) of byte n/8.
- R4: A byte is taken when `byte_valid_i` and `byte_ready_o` are both high at a clock edge. Ready is high only while the block waits for the next byte. While the upstream stalls, no clock pulse is given.
- R5: If `dev_init_n_i` reads low while bits are being shifted, the load stops with `error_o` set and no further rising edge on `dev_cclk_o`.
- R6: After the last bit of the byte flagged by `byte_last_i`, `dev_din_o` is 1 on every further rising clock edge, and pulses continue until `dev_done_i` reads high. The load then ends with `success_o` set.
- R7: If done has not risen DONE_TIMEOUT_CYCLES cycles after the trailing phase begins, the load ends with `error_o` set.
- R8: `busy_o` is high from the cycle after `start_i` until the result. `success_o` and `error_o` are never both set, each holds until the next `start_i`, and a new start clears them.
- R9: A `start_i` pulse during a load is ignored. Program is not pulsed again, and the load completes unchanged.
- R10: In reset, and right after an asynchronous reset in the middle of a load, the outputs are: program high, clock low, ready low, and busy, success and error all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a full load sequence |
| byte_data_i | input | BYTE_W | Bitstream byte |
| byte_valid_i | input | 1 | Byte present on `byte_data_i` |
| byte_last_i | input | 1 | Byte is the final one of the bitstream |
| byte_ready_o | output | 1 | Loader takes the byte at this edge |
| dev_prog_n_o | output | 1 | Active-low program pin to target |
| dev_din_o | output | 1 | Serial data pin to target |
| dev_cclk_o | output | 1 | Configuration clock to target |
| dev_init_n_i | input | 1 | Active-low init pin from target |
| dev_done_i | input | 1 | Done pin from target |
| busy_o | output | 1 | Load in progress |
| success_o | output | 1 | Last load completed (sticky) |
| error_o | output | 1 | Last load failed (sticky) |

## Verification
The assertions take for granted that the target's init and done pins, and the upstream stream, are already synchronous to `clk`, and that byte data and the last flag are stable while valid is high. The stimulus keeps within this. A target model and a byte source both change their signals only at the falling clock edge. The model moves init and done only in response to the program pin and to observed rising clock edges. The source holds each byte until a handshake and can insert gaps between bytes.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_LOW,
        ST_INIT_WAIT,
        ST_FETCH,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_TRAIL_LO,
        ST_TRAIL_HI,
        ST_PASS,
        ST_FAIL
    } ld_state_e;

endpackage

// File: rtl/cfgl_timer.sv
// Down-counter: loaded with N-1, zero_o rises after N cycles in a state.
module cfgl_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfgl_shifter.sv
// Holds one bitstream byte and presents it MSB first.
module cfgl_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              last_i,
    output logic              msb_o,
    output logic              final_bit_o,
    output logic              last_byte_o
);

    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sreg_q;
    logic [CW-1:0]     idx_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
            last_q <= 1'b0;
        end else if (load_i) begin
            sreg_q <= data_i;
            idx_q  <= '0;
            last_q <= last_i;
        end else if (shift_i) begin
            sreg_q <= sreg_q << 1;
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign msb_o       = sreg_q[BYTE_W-1];
    assign final_bit_o = (idx_q == LAST_IDX);
    assign last_byte_o = last_q;

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int BYTE_W              = 8,
    parameter int PROG_LOW_CYCLES     = 16,
    parameter int HALF_PERIOD_CYCLES  = 2,
    parameter int INIT_TIMEOUT_CYCLES = 1000,
    parameter int DONE_TIMEOUT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    output logic              dev_prog_n_o,
    output logic              dev_din_o,
    output logic              dev_cclk_o,
    input  logic              dev_init_n_i,
    input  logic              dev_done_i,
    output logic              busy_o,
    output logic              success_o,
    output logic              error_o
);

    localparam int PH_MAX = (PROG_LOW_CYCLES > HALF_PERIOD_CYCLES) ? PROG_LOW_CYCLES : HALF_PERIOD_CYCLES;
    localparam int WD_MAX = (INIT_TIMEOUT_CYCLES > DONE_TIMEOUT_CYCLES) ? INIT_TIMEOUT_CYCLES : DONE_TIMEOUT_CYCLES;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WD_W   = $clog2(WD_MAX + 1);

    localparam logic [PH_W-1:0] PH_PROG = PH_W'(PROG_LOW_CYCLES - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_PERIOD_CYCLES - 1);
    localparam logic [WD_W-1:0] WD_INIT = WD_W'(INIT_TIMEOUT_CYCLES - 1);
    localparam logic [WD_W-1:0] WD_DONE = WD_W'(DONE_TIMEOUT_CYCLES - 1);

    ld_state_e       state_q, state_d;
    logic            ph_load, ph_zero;
    logic [PH_W-1:0] ph_val;
    logic            wd_load, wd_zero;
    logic [WD_W-1:0] wd_val;
    logic            sh_load, sh_shift, sh_msb, sh_final, sh_last;

    cfgl_timer #(.W(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ph_load),
        .value_i (ph_val),
        .zero_o  (ph_zero)
    );

    cfgl_timer #(.W(WD_W)) u_watchdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (wd_load),
        .value_i (wd_val),
        .zero_o  (wd_zero)
    );

    cfgl_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load),
        .shift_i     (sh_shift),
        .data_i      (byte_data_i),
        .last_i      (byte_last_i),
        .msb_o       (sh_msb),
        .final_bit_o (sh_final),
        .last_byte_o (sh_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer/shifter control
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = PH_HALF;
        wd_load  = 1'b0;
        wd_val   = WD_DONE;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start_i) begin
                    state_d = ST_PROG_LOW;
                    ph_load = 1'b1;
                    ph_val  = PH_PROG;
                end
            end
            ST_PROG_LOW: begin
                if (ph_zero) begin
                    state_d = ST_INIT_WAIT;
                    wd_load = 1'b1;
                    wd_val  = WD_INIT;
                end
            end
            ST_INIT_WAIT: begin
                if (dev_init_n_i) begin
                    state_d = ST_FETCH;
                end else if (wd_zero) begin
                    state_d = ST_FAIL;
                end
            end
            ST_FETCH: begin
                if (byte_valid_i) begin
                    state_d = ST_SHIFT_LO;
                    sh_load = 1'b1;
                    ph_load = 1'b1;
                end
            end
            ST_SHIFT_LO: begin
                if (!dev_init_n_i) begin
                    state_d = ST_FAIL;
                end else if (ph_zero) begin
                    state_d = ST_SHIFT_HI;
                    ph_load = 1'b1;
                end
            end
            ST_SHIFT_HI: begin
                if (!dev_init_n_i) begin
                    state_d = ST_FAIL;
                end else if (ph_zero) begin
                    if (!sh_final) begin
                        state_d  = ST_SHIFT_LO;
                        sh_shift = 1'b1;
                        ph_load  = 1'b1;
                    end else if (sh_last) begin
                        state_d = ST_TRAIL_LO;
                        ph_load = 1'b1;
                        wd_load = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_TRAIL_LO: begin
                if (dev_done_i) begin
                    state_d = ST_PASS;
                end else if (wd_zero) begin
                    state_d = ST_FAIL;
                end else if (ph_zero) begin
                    state_d = ST_TRAIL_HI;
                    ph_load = 1'b1;
                end
            end
            ST_TRAIL_HI: begin
                if (dev_done_i) begin
                    state_d = ST_PASS;
                end else if (wd_zero) begin
                    state_d = ST_FAIL;
                end else if (ph_zero) begin
                    state_d = ST_TRAIL_LO;
                    ph_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs (Moore, decoded from the state register)
    always_comb begin
        dev_prog_n_o = 1'b1;
        dev_cclk_o   = 1'b0;
        dev_din_o    = 1'b1;
        byte_ready_o = 1'b0;
        busy_o       = 1'b1;
        success_o    = 1'b0;
        error_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_PROG_LOW:  dev_prog_n_o = 1'b0;
            ST_INIT_WAIT: ;
            ST_FETCH: begin
                byte_ready_o = 1'b1;
                dev_din_o    = sh_msb;
            end
            ST_SHIFT_LO:  dev_din_o = sh_msb;
            ST_SHIFT_HI: begin
                dev_din_o  = sh_msb;
                dev_cclk_o = 1'b1;
            end
            ST_TRAIL_LO:  ;
            ST_TRAIL_HI:  dev_cclk_o = 1'b1;
            ST_PASS: begin
                busy_o    = 1'b0;
                success_o = 1'b1;
            end
            ST_FAIL: begin
                busy_o  = 1'b0;
                error_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
    parameter int PROG_LOW_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_valid_i,
    input logic byte_ready_o,
    input logic dev_prog_n_o,
    input logic dev_din_o,
    input logic dev_cclk_o,
    input logic dev_done_i,
    input logic success_o
);

    int low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= 0;
        end else if (!dev_prog_n_o) begin
            low_cnt_q <= low_cnt_q + 1;
        end else begin
            low_cnt_q <= 0;
        end
    end

    // R1
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_prog_n_o) |-> (low_cnt_q >= PROG_LOW_CYCLES));

    // R1
    no_clk_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_prog_n_o |-> !dev_cclk_o);

    // R3
    din_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_cclk_o) |-> $stable(dev_din_o));

    // R4
    one_byte_per_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready_o && byte_valid_i) |=> !byte_ready_o);

    // R6
    success_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(success_o) |-> $past(dev_done_i));

    // R8
    success_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (success_o && !start_i) |=> success_o);

endmodule

bind cfg_serial_loader cfgl_checker #(.PROG_LOW_CYCLES(PROG_LOW_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .dev_prog_n_o (dev_prog_n_o),
    .dev_din_o    (dev_din_o),
    .dev_cclk_o   (dev_cclk_o),
    .dev_done_i   (dev_done_i),
    .success_o    (success_o)
);

// File: tb/cfg_serial_loader_test.sv
`timescale 1ns/1ps
module cfg_serial_loader_test;

    localparam int P_PROG = 6;
    localparam int P_HALF = 2;
    localparam int P_INIT_TO = 30;
    localparam int P_DONE_TO = 40;

    typedef struct packed {
        logic [7:0] init_dly;
        logic [7:0] nbytes;
        logic [7:0] seed;
        logic [7:0] done_after;
        logic [7:0] err_bit;
        logic [3:0] gap;
        logic       pass_exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd3,   8'd2, 8'hA5, 8'd2,   8'd0,  4'd0, 1'b1},
        '{8'd10,  8'd4, 8'h3C, 8'd0,   8'd0,  4'd3, 1'b1},
        '{8'd200, 8'd2, 8'h11, 8'd1,   8'd0,  4'd0, 1'b0},
        '{8'd2,   8'd3, 8'h5E, 8'd1,   8'd13, 4'd0, 1'b0},
        '{8'd1,   8'd2, 8'hC3, 8'd200, 8'd0,  4'd1, 1'b0},
        '{8'd0,   8'd1, 8'hFF, 8'd5,   8'd0,  4'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic src_valid = 1'b0;
    logic src_last = 1'b0;
    logic ready, prog_n, din, cclk;
    logic init_n = 1'b0;
    logic done = 1'b0;
    logic busy, success, error;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_init_dly = 0, m_nbits = 0, m_done_after = 0, m_err_bit = 0;
    int m_nbytes = 0, m_gap = 0;
    logic [7:0] stream [0:15];
    logic cap [0:255];
    int rise_cnt = 0, trail_bad = 0, early_rise = 0, early_ready = 0;
    int prog_low_len = 0, prog_falls = 0;
    int src_idx = 0, gap_cnt = 0;
    bit hs_pend = 1'b0;

    always #2.5 clk = ~clk;

    cfg_serial_loader #(
        .BYTE_W(8),
        .PROG_LOW_CYCLES(P_PROG),
        .HALF_PERIOD_CYCLES(P_HALF),
        .INIT_TIMEOUT_CYCLES(P_INIT_TO),
        .DONE_TIMEOUT_CYCLES(P_DONE_TO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .byte_data_i(src_data), .byte_valid_i(src_valid), .byte_last_i(src_last),
        .byte_ready_o(ready), .dev_prog_n_o(prog_n), .dev_din_o(din),
        .dev_cclk_o(cclk), .dev_init_n_i(init_n), .dev_done_i(done),
        .busy_o(busy), .success_o(success), .error_o(error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input logic [7:0] seed, input int i);
        return (seed + 8'(i * 29)) ^ 8'(i << 3);
    endfunction

    // Target device model: acts at falling edges only
    initial begin : device_model
        bit prog_prev = 1'b1;
        bit cclk_prev = 1'b0;
        bit armed = 1'b0;
        int dly = 0;
        forever begin
            @(negedge clk);
            if (!prog_n) begin
                if (prog_prev) begin
                    prog_falls++;
                    prog_low_len = 0;
                end
                prog_low_len++;
                init_n = 1'b0; done = 1'b0; rise_cnt = 0; dly = 0; armed = 1'b1;
                trail_bad = 0; early_rise = 0; early_ready = 0;
            end else begin
                if (ready && !init_n) early_ready++;
                if (armed) begin
                    if (dly >= m_init_dly) begin
                        init_n = 1'b1;
                        armed = 1'b0;
                    end else begin
                        dly++;
                    end
                end
                if (cclk && !cclk_prev) begin
                    if (!init_n) early_rise++;
                    if (rise_cnt < m_nbits) cap[rise_cnt] = din;
                    else if (!din) trail_bad++;
                    rise_cnt++;
                    if (m_err_bit != 0 && rise_cnt == m_err_bit) init_n = 1'b0;
                    if (rise_cnt == m_nbits + m_done_after) done = 1'b1;
                end
            end
            prog_prev = prog_n;
            cclk_prev = cclk;
        end
    end

    // Byte source: acts at falling edges only
    initial begin : byte_source
        forever begin
            @(negedge clk);
            if (hs_pend) begin
                src_idx++;
                gap_cnt = m_gap;
            end else if (gap_cnt > 0) begin
                gap_cnt--;
            end
            src_valid = (src_idx < m_nbytes) && (gap_cnt == 0);
            src_data  = (src_idx < 16) ? stream[src_idx] : 8'h00;
            src_last  = (src_idx == m_nbytes - 1);
            hs_pend   = src_valid && ready;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic setup(input vec_t v);
        m_init_dly   = int'(v.init_dly);
        m_nbytes     = int'(v.nbytes);
        m_nbits      = 8 * int'(v.nbytes);
        m_done_after = int'(v.done_after);
        m_err_bit    = int'(v.err_bit);
        m_gap        = int'(v.gap);
        for (int i = 0; i < 16; i++) stream[i] = gen_byte(v.seed, i);
        src_idx = 0;
        gap_cnt = 0;
    endtask

    task automatic run_vec(input vec_t v, input int restart_at);
        int n = 0;
        int bad = 0;
        string tag;
        setup(v);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: busy and flags cleared after start
        check(busy && !success && !error, "R8", "busy after start", {busy, success, error}, 3'b100);
        while (!(success || error) && n < 4000) begin
            @(negedge clk);
            n++;
            start = (restart_at != 0 && n == restart_at);
        end
        start = 1'b0;
        if (v.pass_exp) tag = "R6";
        else if (m_init_dly > P_INIT_TO) tag = "R2";
        else if (m_err_bit != 0) tag = "R5";
        else tag = "R7";
        check(success == v.pass_exp && error == !v.pass_exp, tag, "result",
              {success, error}, {v.pass_exp, !v.pass_exp});
        check(prog_low_len == P_PROG && prog_falls == 1, "R1", "program low cycles",
              prog_low_len, P_PROG);
        check(early_rise == 0 && early_ready == 0, "R2", "activity before init high",
              early_rise + early_ready, 0);
        if (v.pass_exp) begin
            for (int b = 0; b < m_nbytes; b++)
                for (int k = 0; k < 8; k++)
                    if (cap[b*8+k] !== stream[b][7-k]) bad++;
            check(bad == 0, "R3", "bits captured MSB first", bad, 0);
            check(src_idx == m_nbytes, "R4", "bytes consumed", src_idx, m_nbytes);
            check(rise_cnt - m_nbits == m_done_after, "R6", "trailing pulses",
                  rise_cnt - m_nbits, m_done_after);
            check(trail_bad == 0, "R6", "trailing data ones", trail_bad, 0);
        end else if (tag == "R2") begin
            check(rise_cnt == 0, "R2", "no pulses on init timeout", rise_cnt, 0);
        end else if (tag == "R5") begin
            check(rise_cnt == m_err_bit, "R5", "pulses stop at init low", rise_cnt, m_err_bit);
        end else begin
            check(rise_cnt > m_nbits && trail_bad == 0, "R7", "trailing ones before timeout",
                  rise_cnt, m_nbits + 1);
        end
        repeat (10) @(negedge clk);
        check(success == v.pass_exp && error == !v.pass_exp && !busy, "R8", "flags held",
              {busy, success, error}, {1'b0, v.pass_exp, !v.pass_exp});
        prog_falls = 0;
    endtask

    initial begin : main
        vec_t rv;
        repeat (5) @(negedge clk);
        // R10: reset state
        check(prog_n && !cclk && !ready && !busy && !success && !error, "R10", "reset state",
              {prog_n, cclk, ready, busy, success, error}, 6'b100000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(prog_n && !busy, "R10", "idle after reset", {prog_n, busy}, 2'b10);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 0);

        // R9: start during a load is ignored
        rv = '{8'd4, 8'd2, 8'h77, 8'd3, 8'd0, 4'd0, 1'b1};
        run_vec(rv, 30);

        // R10: asynchronous reset in the middle of a load
        setup(rv);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (25) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(prog_n && !cclk && !ready && !busy && !success && !error, "R10", "mid-load reset",
              {prog_n, cclk, ready, busy, success, error}, 6'b100000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule